// File: doc/BRIEF.md
# Amplifier Protection Fault Controller

This block turns the protection conditions of a switching audio amplifier into two decisions: whether the power stage may drive its outputs or must float them in high impedance, and whether the active-low open-drain fault pin is pulled low. It also reports when the amplifier sits in its low-current shutdown state. It takes an active-low shutdown request, a short-circuit detect pulse, a DC-fault flag, and a pair of over-temperature comparator flags: one for the trip point and one for the cooler release point.

Each fault type has its own rule for clearing and for reporting. A short circuit latches and is reported on the fault pin, and a low pulse on the shutdown input clears it. This lets the fault pin be wired back to the shutdown input so the block recovers by itself. A DC fault is reported and survives any shutdown cycling, and only power-on reset removes it. Over-temperature floats the outputs, is never reported, and releases only when the separate release flag is seen. The short-circuit and thermal inputs are asynchronous and pass through a synchroniser before use. The power-on reset is asserted asynchronously and released synchronously.

Top module: `amp_prot_ctrl`

## Requirements
- R1: While power-on reset is held and until the third clock edge after its release, the outputs are out_hiz=1, fault_n=1, lowpwr=1. From that edge on, with shutdown_n high and no condition active, the outputs are out_hiz=0, fault_n=1, lowpwr=0.
- R2: When shutdown_n is sampled low at a clock edge, from that edge lowpwr=1 and out_hiz=1. The shutdown input alone never pulls fault_n low.
- R3: A short_det pulse seen while shutdown_n is high latches a short fault SYNC_STAGES+1 edges later: fault_n=0 and out_hiz=1. These hold while shutdown_n stays high.
- R4: The short latch clears at the first edge where shutdown_n is low. Operation resumes at the edge where shutdown_n is next sampled high.
- R5: With fault_n wired to shutdown_n, a short fault goes through latch, clear and resume in three consecutive cycles.
- R6: A short_det pulse whose synchronised copy arrives while shutdown_n is low is ignored.
- R7: dc_fault sampled high while shutdown_n is high sets, at that edge, fault_n=0 and out_hiz=1. Cycling shutdown_n does not clear it. Only power-on reset does.
- R8: dc_fault sampled while shutdown_n is low is ignored.
- R9: ot_trip floats the outputs (out_hiz=1) SYNC_STAGES+1 edges after it rises. fault_n stays 1 and lowpwr stays 0.
- R10: The thermal condition is not latched by a shutdown cycle, but it persists after ot_trip falls until ot_release is seen. When both flags are high, the trip wins.
- R11: When several conditions are active together, out_hiz stays 1 until every one has cleared.
- R12: The synchronised inputs take exactly SYNC_STAGES+1 clock edges to reach the outputs. The outputs do not change before that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| shutdown_n | input | 1 | Shutdown request, active low |
| short_det | input | 1 | Output short detected, asynchronous pulse |
| dc_fault | input | 1 | DC output condition detected, synchronous |
| ot_trip | input | 1 | Die above trip temperature, asynchronous |
| ot_release | input | 1 | Die cooled below release point, asynchronous |
| out_hiz | output | 1 | 1 = power stage outputs in high impedance |
| fault_n | output | 1 | Fault pin drive, 0 = pull low |
| lowpwr | output | 1 | 1 = low-current shutdown state |

## Verification
The bench builds the block with SYNC_STAGES=2, so every synchronised input reaches the outputs on the third edge and the latency can be checked edge by edge. With five single-bit inputs, the bench applies every ordered pair of the 32 input patterns from reset, followed by an idle period. This covers every overlap of the three fault types with shutdown and with each other, including a trip and a release flag raised together. The feedback wiring from fault_n to shutdown_n is exercised separately to cover automatic recovery.

// File: rtl/apc_pkg.sv
package apc_pkg;
  typedef enum logic [2:0] {
    ST_SHDN  = 3'd0,
    ST_RUN   = 3'd1,
    ST_SCLAT = 3'd2,
    ST_DCLAT = 3'd3,
    ST_THERM = 3'd4
  } apc_state_e;
endpackage

// File: rtl/apc_rst_sync.sv
module apc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/apc_sync.sv
module apc_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= {stg_q[STAGES-2:0], d};
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/apc_latches.sv
module apc_latches (
  input  logic clk,
  input  logic rst_n,
  input  logic sd_n,
  input  logic sc_s,
  input  logic dc_in,
  input  logic trip_s,
  input  logic rel_s,
  output logic sd_q,
  output logic sc_lat,
  output logic dc_lat,
  output logic ot_hot
);
  logic sd_d, sc_d, dc_d, hot_d;

  always_comb begin
    sd_d = sd_n;
    sc_d = sd_n ? (sc_lat | sc_s) : 1'b0;
    dc_d = dc_lat | (dc_in & sd_n);
    if (trip_s)     hot_d = 1'b1;
    else if (rel_s) hot_d = 1'b0;
    else            hot_d = ot_hot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_q   <= 1'b0;
      sc_lat <= 1'b0;
      dc_lat <= 1'b0;
      ot_hot <= 1'b0;
    end else begin
      sd_q   <= sd_d;
      sc_lat <= sc_d;
      dc_lat <= dc_d;
      ot_hot <= hot_d;
    end
  end
endmodule

// File: rtl/apc_decode.sv
module apc_decode
  import apc_pkg::*;
(
  input  logic sd_q,
  input  logic sc_lat,
  input  logic dc_lat,
  input  logic ot_hot,
  output logic out_hiz,
  output logic fault_n,
  output logic lowpwr
);
  apc_state_e st;

  always_comb begin
    if (dc_lat)      st = ST_DCLAT;
    else if (sc_lat) st = ST_SCLAT;
    else if (!sd_q)  st = ST_SHDN;
    else if (ot_hot) st = ST_THERM;
    else             st = ST_RUN;
  end

  assign out_hiz = (st != ST_RUN);
  assign fault_n = !((st == ST_DCLAT) || (st == ST_SCLAT));
  assign lowpwr  = !sd_q;
endmodule

// File: rtl/amp_prot_ctrl.sv
module amp_prot_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shutdown_n,
  input  logic short_det,
  input  logic dc_fault,
  input  logic ot_trip,
  input  logic ot_release,
  output logic out_hiz,
  output logic fault_n,
  output logic lowpwr
);
  localparam int NSYNC = 3;

  logic             rst_q;
  logic [NSYNC-1:0] async_in, sync_out;
  logic             sd_q, sc_lat, dc_lat, ot_hot;

  apc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_q)
  );

  assign async_in = {ot_release, ot_trip, short_det};

  apc_sync #(.STAGES(SYNC_STAGES), .WIDTH(NSYNC)) u_sync (
    .clk(clk), .rst_n(rst_q), .d(async_in), .q(sync_out)
  );

  apc_latches u_lat (
    .clk(clk), .rst_n(rst_q), .sd_n(shutdown_n),
    .sc_s(sync_out[0]), .dc_in(dc_fault),
    .trip_s(sync_out[1]), .rel_s(sync_out[2]),
    .sd_q(sd_q), .sc_lat(sc_lat), .dc_lat(dc_lat), .ot_hot(ot_hot)
  );

  apc_decode u_dec (
    .sd_q(sd_q), .sc_lat(sc_lat), .dc_lat(dc_lat), .ot_hot(ot_hot),
    .out_hiz(out_hiz), .fault_n(fault_n), .lowpwr(lowpwr)
  );
endmodule

// File: rtl/apc_chk.sv
module apc_chk (
  input logic clk,
  input logic rst_q,
  input logic shutdown_n,
  input logic sc_lat,
  input logic dc_lat,
  input logic ot_hot,
  input logic out_hiz,
  input logic fault_n,
  input logic lowpwr
);
  logic prim_ok;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) prim_ok <= 1'b0;
    else        prim_ok <= 1'b1;
  end

  AST_SD_LOWPWR: assert property (@(posedge clk) disable iff (!rst_q)
    prim_ok |-> (lowpwr == !$past(shutdown_n)));                           // R2
  AST_MUTE_HIZ: assert property (@(posedge clk) disable iff (!rst_q)
    lowpwr |-> out_hiz);                                                   // R2
  AST_FAULT_HIZ: assert property (@(posedge clk) disable iff (!rst_q)
    !fault_n |-> out_hiz);                                                 // R3
  AST_SC_CLEAR: assert property (@(posedge clk) disable iff (!rst_q)
    (prim_ok && !$past(shutdown_n)) |-> !sc_lat);                          // R4
  AST_DC_STICKY: assert property (@(posedge clk) disable iff (!rst_q)
    (prim_ok && $past(dc_lat)) |-> dc_lat);                                // R7
  AST_DC_GATED: assert property (@(posedge clk) disable iff (!rst_q)
    (prim_ok && !$past(dc_lat) && !$past(shutdown_n)) |-> !dc_lat);        // R8
  AST_THERM_SILENT: assert property (@(posedge clk) disable iff (!rst_q)
    (ot_hot && !sc_lat && !dc_lat) |-> (fault_n && out_hiz));              // R9
endmodule

bind amp_prot_ctrl apc_chk chk_i (
  .clk(clk), .rst_q(rst_q), .shutdown_n(shutdown_n),
  .sc_lat(sc_lat), .dc_lat(dc_lat), .ot_hot(ot_hot),
  .out_hiz(out_hiz), .fault_n(fault_n), .lowpwr(lowpwr)
);

// File: tb/amp_prot_ctrl_tb.sv
`timescale 1ns/1ps
module amp_prot_ctrl_tb_top;
  localparam int SYNC = 2;
  localparam int LAT  = SYNC + 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, sd_drv, fb, sc_det, dc_flt, ot_trip, ot_rel, sweep_on;
  logic out_hiz, fault_n, lowpwr;
  wire  sd_n = fb ? fault_n : sd_drv;
  int   nchk = 0, nfail = 0;

  amp_prot_ctrl #(.SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst_n(rst_n), .shutdown_n(sd_n), .short_det(sc_det),
    .dc_fault(dc_flt), .ot_trip(ot_trip), .ot_release(ot_rel),
    .out_hiz(out_hiz), .fault_n(fault_n), .lowpwr(lowpwr)
  );

  task automatic chk(string r, logic eh, logic ef, logic el);
    nchk++;
    if ({out_hiz, fault_n, lowpwr} !== {eh, ef, el}) begin
      nfail++;
      $display("FAIL %s: hiz/fault_n/lowpwr = %b%b%b expected %b%b%b",
               r, out_hiz, fault_n, lowpwr, eh, ef, el);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic apply(logic [4:0] v);
    sd_drv = v[0]; sc_det = v[1]; dc_flt = v[2]; ot_trip = v[3]; ot_rel = v[4];
  endtask

  task automatic do_reset();
    rst_n = 1'b0; apply(5'b00001);
    step(2);
    rst_n = 1'b1;
    step(3);
  endtask

  // Expected-behaviour model, derived from the requirements, for the sweep.
  logic m_r1, m_r2;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin m_r1 <= 1'b0; m_r2 <= 1'b0; end
    else begin m_r1 <= 1'b1; m_r2 <= m_r1; end

  logic [SYNC-1:0] m_sc, m_tr, m_rl;
  logic m_sdq, m_scl, m_dcl, m_hot;
  always @(posedge clk or negedge m_r2)
    if (!m_r2) begin
      m_sc <= '0; m_tr <= '0; m_rl <= '0;
      m_sdq <= 1'b0; m_scl <= 1'b0; m_dcl <= 1'b0; m_hot <= 1'b0;
    end else begin
      m_sc  <= {m_sc[SYNC-2:0], sc_det};
      m_tr  <= {m_tr[SYNC-2:0], ot_trip};
      m_rl  <= {m_rl[SYNC-2:0], ot_rel};
      m_sdq <= sd_n;
      m_scl <= sd_n && (m_scl || m_sc[SYNC-1]);
      m_dcl <= m_dcl || (dc_flt && sd_n);
      m_hot <= m_tr[SYNC-1] ? 1'b1 : (m_rl[SYNC-1] ? 1'b0 : m_hot);
    end

  always @(posedge clk)
    if (sweep_on) begin
      #2;
      chk("R11 sweep", !m_sdq || m_scl || m_dcl || m_hot, !(m_scl || m_dcl), !m_sdq);
    end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R1 watchdog: run still active after 150000 cycles, expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    fb = 1'b0; sweep_on = 1'b0; rst_n = 1'b0; apply(5'b00001);
    step(1);
    chk("R1 in reset", 1, 1, 1);
    rst_n = 1'b1;
    step(2);
    chk("R1 before release", 1, 1, 1);
    step(1);
    chk("R1 running", 0, 1, 0);

    // R2 shutdown
    sd_drv = 1'b0; step(1);
    chk("R2 shutdown", 1, 1, 1);
    sd_drv = 1'b1; step(1);
    chk("R2 resume", 0, 1, 0);

    // R3 / R12 short latch
    sc_det = 1'b1; step(1); sc_det = 1'b0;
    chk("R12 early 1", 0, 1, 0);
    step(1);
    chk("R12 early 2", 0, 1, 0);
    step(1);
    chk("R3 latched", 1, 0, 0);
    step(3);
    chk("R3 held", 1, 0, 0);
    // R4 clear by shutdown cycle
    sd_drv = 1'b0; step(1);
    chk("R4 cleared", 1, 1, 1);
    sd_drv = 1'b1; step(1);
    chk("R4 resume", 0, 1, 0);

    // R6 short while shut down
    sd_drv = 1'b0; sc_det = 1'b1; step(1); sc_det = 1'b0; step(4);
    chk("R6 in shutdown", 1, 1, 1);
    sd_drv = 1'b1; step(1);
    chk("R6 ignored", 0, 1, 0);

    // R5 automatic recovery through feedback
    fb = 1'b1;
    sc_det = 1'b1; step(1); sc_det = 1'b0; step(LAT - 1);
    chk("R5 latch", 1, 0, 0);
    step(1);
    chk("R5 clear", 1, 1, 1);
    step(1);
    chk("R5 resume", 0, 1, 0);
    fb = 1'b0; sd_drv = 1'b1;

    // R9 / R10 thermal
    ot_trip = 1'b1; step(LAT - 1);
    chk("R12 thermal early", 0, 1, 0);
    step(1);
    chk("R9 hot", 1, 1, 0);
    ot_trip = 1'b0; step(4);
    chk("R10 persists", 1, 1, 0);
    sd_drv = 1'b0; step(1); sd_drv = 1'b1; step(1);
    chk("R10 not cleared by shutdown", 1, 1, 0);
    ot_trip = 1'b1; ot_rel = 1'b1; step(4);
    chk("R10 trip priority", 1, 1, 0);
    ot_trip = 1'b0; step(LAT + 1);
    chk("R10 released", 0, 1, 0);
    ot_rel = 1'b0;

    // R11 combined short + thermal
    sc_det = 1'b1; ot_trip = 1'b1; step(1); sc_det = 1'b0; step(LAT - 1);
    chk("R11 both", 1, 0, 0);
    sd_drv = 1'b0; step(1); sd_drv = 1'b1; step(1);
    chk("R11 still hot", 1, 1, 0);
    ot_trip = 1'b0; ot_rel = 1'b1; step(LAT + 1);
    chk("R11 all clear", 0, 1, 0);
    ot_rel = 1'b0;

    // R8 DC while shut down
    sd_drv = 1'b0; dc_flt = 1'b1; step(1); dc_flt = 1'b0; sd_drv = 1'b1; step(1);
    chk("R8 ignored", 0, 1, 0);
    // R7 DC latch
    dc_flt = 1'b1; step(1); dc_flt = 1'b0;
    chk("R7 set", 1, 0, 0);
    sd_drv = 1'b0; step(1);
    chk("R7 in shutdown", 1, 0, 1);
    sd_drv = 1'b1; step(1);
    chk("R7 survives shutdown", 1, 0, 0);
    do_reset();
    chk("R7 reset clears", 0, 1, 0);

    // Sweep over ordered pairs of input patterns
    sweep_on = 1'b1;
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 32; b++) begin
        do_reset();
        apply(5'(a)); step(3);
        apply(5'(b)); step(3);
        apply(5'b00001); step(4);
      end
    end
    sweep_on = 1'b0;
    step(1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule